// File: doc/BRIEF.md
# General-Purpose I/O Port Register Block

This block is the register front end of a 32-pin general-purpose I/O port. A simple
32-bit register bus with byte addresses writes three configuration registers (pin
direction, open-drain enable and output data) and reads them back. From those registers
the block drives per-pin pad controls: the output level, the output enable and an
open-drain flag. It also brings the pin levels into the clock domain through a two-flop
synchroniser so that software can read them.

Register bit (31 − n) belongs to pin n, so pin 0 sits in the most significant bit of
every register. The pad-side vectors are indexed by pin number. A read of the data
register gives output pins their latched value and input pins their synchronised pad
level. A parameter names pins that may only ever be inputs. Offsets 0x0C to 0x18 are
kept for a separate interrupt block and behave as empty here.

Top module: `gpio_port_regs`

## Requirements
- R1: A synchronous active-high reset clears the direction, open-drain and data registers to 0. After reset every pad output enable is 0, and the direction and open-drain registers read back 0.
- R2: The direction register is at byte offset 0x00, the open-drain register at 0x04 and the data register at 0x08. A write takes effect at the clock edge where bus_wr_en is 1. bus_rdata shows, one edge after bus_addr is presented, the register at that address as it stood before that edge.
- R3: Pin n corresponds to register bit 31 − n. pin_in[n], pad_out[n], pad_oe[n] and pad_od[n] all refer to pin n.
- R4: A direction bit of 1 makes the pin an output and 0 makes it an input. With the open-drain bit at 0, pad_oe[n] equals the direction bit and pad_out[n] equals the data bit.
- R5: A data register read returns, bit by bit, the synchronised pin level where the direction bit is 0 and the latched data bit where the direction bit is 1.
- R6: Pins named in the INPUT_ONLY parameter (by default pins 28 to 31, register bits 3 to 0) keep their direction bits at 0: writes cannot set them, they read back 0 and their pad_oe is never 1.
- R7: With the open-drain bit at 1, pad_od[n] is 1 and pad_out[n] is 0. pad_oe[n] is 1 only while the pin is an output and its data bit is 0, and is 0 otherwise.
- R8: A change on pin_in passes through two flops. In a data register read with the address held, the new level first shows after the third clock edge following the change.
- R9: Writes to offsets 0x0C, 0x10, 0x14 and 0x18, to any other unlisted offset, or to any address whose two low bits are not 00, change no register and no pad output. Reads of all such addresses return 0.
- R10: While bus_wr_en is 0, no register and no pad output changes, whatever bus_addr and bus_wdata carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr_en | input | 1 | Write strobe for the current address |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data, bit 31 is pin 0 |
| bus_rdata | output | 32 | Registered read data, bit 31 is pin 0 |
| pin_in | input | 32 | Raw pad input levels, bit n is pin n |
| pad_out | output | 32 | Level driven on each pad |
| pad_oe | output | 32 | Output enable of each pad |
| pad_od | output | 32 | Open-drain mode flag of each pad |

## Verification
The hardest case to reach from the ports is a data register read where output and input
pins sit side by side while the pin levels are still moving through the synchroniser.
In that case one read mixes latched bits with bits that are one or two edges stale. The
bench holds the data address steady, changes pin_in on a falling edge and samples
bus_rdata after the second and the third rising edge. Seeded random sequences then
interleave direction, open-drain and data writes with fresh pin patterns and writes to
empty or misaligned addresses. A reference model in the bench recomputes the merged read
and the pad controls after each step, including attempts to turn the input-only pins
into outputs.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    // Byte offsets of the registers held in this block
    localparam int OFF_DIR  = 'h00;
    localparam int OFF_ODE  = 'h04;
    localparam int OFF_DATA = 'h08;
    // Window owned by the interrupt block: accepted, no storage here
    localparam int OFF_IRQ_FIRST = 'h0C;
    localparam int OFF_IRQ_LAST  = 'h18;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DIR,
        SEL_ODE,
        SEL_DATA,
        SEL_IRQ
    } reg_sel_e;

    // Control bundle for one pad
    typedef struct packed {
        logic drive;
        logic enable;
        logic opendrain;
    } pad_ctl_t;

    // Pad rule: push-pull drives the data level while an output; open-drain
    // only pulls low, and only while an output with data 0.
    function automatic pad_ctl_t pad_rule(input logic dir, input logic ode, input logic dat);
        pad_ctl_t p;
        p.opendrain = ode;
        if (ode) begin
            p.drive  = 1'b0;
            p.enable = dir & ~dat;
        end else begin
            p.drive  = dat;
            p.enable = dir;
        end
        return p;
    endfunction

    // Register bit position that belongs to a given pin
    function automatic int reg_bit(input int pin, input int npins);
        return npins - 1 - pin;
    endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    logic aligned;
    int   byte_off;

    assign aligned  = (addr[1:0] == 2'b00);
    assign byte_off = int'(addr);

    always_comb begin
        sel = SEL_NONE;
        if (aligned) begin
            if (byte_off == OFF_DIR) begin
                sel = SEL_DIR;
            end else if (byte_off == OFF_ODE) begin
                sel = SEL_ODE;
            end else if (byte_off == OFF_DATA) begin
                sel = SEL_DATA;
            end else if (byte_off >= OFF_IRQ_FIRST && byte_off <= OFF_IRQ_LAST) begin
                sel = SEL_IRQ;
            end
        end
    end

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_port_pkg::*;
#(
    parameter int               NPINS  = 32,
    parameter logic [NPINS-1:0] RO_REG = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] ode_q,
    output logic [NPINS-1:0] dat_q
);

    // Mask of direction bits that software may set
    localparam logic [NPINS-1:0] DIR_WRITABLE = ~RO_REG;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
            ode_q <= '0;
            dat_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_DIR:  dir_q <= wdata & DIR_WRITABLE;
                SEL_ODE:  ode_q <= wdata;
                SEL_DATA: dat_q <= wdata;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) begin
                stg[s] <= '0;
            end
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0] dir_q,
    input  logic [NPINS-1:0] ode_q,
    input  logic [NPINS-1:0] dat_q,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_od
);

    // Registers are held in bus order (pin 0 at the MSB); pads use pin order.
    for (genvar n = 0; n < NPINS; n++) begin : g_pin
        localparam int RB = reg_bit(n, NPINS);
        pad_ctl_t ctl;
        assign ctl        = pad_rule(dir_q[RB], ode_q[RB], dat_q[RB]);
        assign pad_out[n] = ctl.drive;
        assign pad_oe[n]  = ctl.enable;
        assign pad_od[n]  = ctl.opendrain;
    end

endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  reg_sel_e         sel,
    input  logic [NPINS-1:0] dir_q,
    input  logic [NPINS-1:0] ode_q,
    input  logic [NPINS-1:0] dat_q,
    input  logic [NPINS-1:0] pin_reg,
    output logic [NPINS-1:0] rdata
);

    logic [NPINS-1:0] merged;
    logic [NPINS-1:0] rd_next;

    // Output pins report the latched value, input pins the synchronised level
    assign merged = (pin_reg & ~dir_q) | (dat_q & dir_q);

    always_comb begin
        case (sel)
            SEL_DIR:  rd_next = dir_q;
            SEL_ODE:  rd_next = ode_q;
            SEL_DATA: rd_next = merged;
            default:  rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else begin
            rdata <= rd_next;
        end
    end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int               NPINS      = 32,
    parameter int               ADDR_W     = 8,
    parameter int               SYNC_DEPTH = 2,
    parameter logic [NPINS-1:0] INPUT_ONLY = 32'hF000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_od
);

    function automatic logic [NPINS-1:0] pin_to_reg(input logic [NPINS-1:0] v);
        logic [NPINS-1:0] r;
        for (int i = 0; i < NPINS; i++) begin
            r[reg_bit(i, NPINS)] = v[i];
        end
        return r;
    endfunction

    // Input-only pin list translated into register bit order
    localparam logic [NPINS-1:0] RO_REG = pin_to_reg(INPUT_ONLY);

    reg_sel_e         sel;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] ode_q;
    logic [NPINS-1:0] dat_q;
    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] pin_reg;

    gpio_addr_dec #(
        .ADDR_W (ADDR_W)
    ) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    gpio_cfg_regs #(
        .NPINS  (NPINS),
        .RO_REG (RO_REG)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_wr_en),
        .sel   (sel),
        .wdata (bus_wdata),
        .dir_q (dir_q),
        .ode_q (ode_q),
        .dat_q (dat_q)
    );

    gpio_in_sync #(
        .W      (NPINS),
        .STAGES (SYNC_DEPTH)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    for (genvar n = 0; n < NPINS; n++) begin : g_in_map
        assign pin_reg[reg_bit(n, NPINS)] = pin_sync[n];
    end

    gpio_pad_drive #(
        .NPINS (NPINS)
    ) u_pads (
        .dir_q   (dir_q),
        .ode_q   (ode_q),
        .dat_q   (dat_q),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .pad_od  (pad_od)
    );

    gpio_rd_mux #(
        .NPINS (NPINS)
    ) u_rd (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel),
        .dir_q   (dir_q),
        .ode_q   (ode_q),
        .dat_q   (dat_q),
        .pin_reg (pin_reg),
        .rdata   (bus_rdata)
    );

endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk #(
    parameter int               NPINS      = 32,
    parameter int               ADDR_W     = 8,
    parameter logic [NPINS-1:0] INPUT_ONLY = 32'hF000_0000
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPINS-1:0]  pad_out,
    input logic [NPINS-1:0]  pad_oe,
    input logic [NPINS-1:0]  pad_od
);

    // R6: input-only pins never have their output enabled
    assert_input_only_R6: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & INPUT_ONLY) == '0);

    // R7: an open-drain pin never drives a high level
    assert_od_low_only_R7: assert property (@(posedge clk) disable iff (rst)
        (pad_out & pad_od) == '0);

    // R10: no write strobe, no change on any pad control
    assert_idle_stable_R10: assert property (@(posedge clk) disable iff (rst)
        !bus_wr_en |=> ($stable(pad_out) && $stable(pad_oe) && $stable(pad_od)));

    // R9: writes beyond the data register or misaligned leave pads untouched
    assert_empty_write_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && (int'(bus_addr) > 8 || bus_addr[1:0] != 2'b00))
        |=> ($stable(pad_out) && $stable(pad_oe) && $stable(pad_od)));

endmodule

bind gpio_port_regs gpio_port_regs_chk #(
    .NPINS      (NPINS),
    .ADDR_W     (ADDR_W),
    .INPUT_ONLY (INPUT_ONLY)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_od    (pad_od)
);

// File: tb/gpio_port_regs_bench.sv
`timescale 1ns/1ps
module gpio_port_regs_bench;

    localparam int          CLK_NS = 8;
    localparam logic [31:0] RO_PINS = 32'hF000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic [31:0] pad_od;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model, bus bit order
    logic [31:0] m_dir = '0;
    logic [31:0] m_ode = '0;
    logic [31:0] m_dat = '0;
    logic [31:0] m_pins = '0;

    always #(CLK_NS/2) clk = ~clk;

    gpio_port_regs u_gpio_port_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr_en (bus_wr_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .pad_od    (pad_od)
    );

    function automatic logic [31:0] flip(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[31-i] = v[i];
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00:   return m_dir;
            8'h04:   return m_ode;
            8'h08:   return (flip(m_pins) & ~m_dir) | (m_dat & m_dir);
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
        case (a)
            8'h00: m_dir = d & ~flip(RO_PINS);
            8'h04: m_ode = d;
            8'h08: m_dat = d;
            default: ;
        endcase
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr  = a;
        bus_wr_en = 1'b0;
        @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a);
        logic [31:0] v;
        rd(a, v);
        chk(req, $sformatf("read@%h", a), v, exp_read(a));
    endtask

    task automatic set_pins(input logic [31:0] v);
        @(negedge clk);
        pin_in = v;
        m_pins = v;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic chk_pads(input string req);
        logic [31:0] e_out, e_oe, e_od;
        for (int n = 0; n < 32; n++) begin
            logic d, o, t;
            d = m_dir[31-n];
            o = m_ode[31-n];
            t = m_dat[31-n];
            e_od[n]  = o;
            e_out[n] = o ? 1'b0 : t;
            e_oe[n]  = o ? (d & ~t) : d;
        end
        chk(req, "pad_out", pad_out, e_out);
        chk(req, "pad_oe",  pad_oe,  e_oe);
        chk(req, "pad_od",  pad_od,  e_od);
    endtask

    initial begin : watchdog
        #(CLK_NS * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        logic [7:0]  addrs [10];
        void'($urandom(32'h5EED_0042));
        addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h02, 8'h09};

        // R1: reset state
        pin_in = 32'hA5C3_0F96;
        m_pins = 32'hA5C3_0F96;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        chk("R1", "pad_oe after reset", pad_oe, 32'h0);
        chk_pads("R1");
        rd_chk("R1", 8'h00);
        rd_chk("R1", 8'h04);
        rd_chk("R5", 8'h08);

        // R3/R4: pin 0 is the MSB, pin 31 the LSB
        wr(8'h00, 32'h8000_0000);
        wr(8'h08, 32'h8000_0001);
        chk("R3", "pin0 oe", pad_oe, 32'h0000_0001);
        chk("R3", "pin0 out", pad_out & 32'h1, 32'h1);
        chk_pads("R4");
        rd_chk("R2", 8'h00);
        rd_chk("R2", 8'h08);

        // R6: input-only pins refuse to become outputs
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v);
        chk("R6", "dir readback", v, 32'hFFFF_FFF0);
        chk("R6", "ro pad_oe", pad_oe & RO_PINS, 32'h0);

        // R5: merged data read
        wr(8'h00, 32'hFFFF_0000);
        wr(8'h08, 32'h1234_5678);
        set_pins(32'h6C3E_91B7);
        rd_chk("R5", 8'h08);

        // R7: open-drain pads
        wr(8'h00, 32'hFFFF_FF00);
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h08, 32'h0F0F_0F0F);
        chk("R7", "od pad_out", pad_out, 32'h0);
        chk_pads("R7");

        // R8: two synchroniser flops, then the read register
        wr(8'h04, 32'h0);
        wr(8'h00, 32'h0);
        set_pins(32'h0000_0000);
        @(negedge clk);
        bus_addr = 8'h08;
        pin_in   = 32'hFFFF_FFFF;
        @(negedge clk);
        @(negedge clk);
        chk("R8", "after 2nd edge", bus_rdata, 32'h0);
        @(negedge clk);
        chk("R8", "after 3rd edge", bus_rdata, 32'hFFFF_FFFF);
        m_pins = 32'hFFFF_FFFF;

        // R9: empty and misaligned addresses
        wr(8'h00, 32'h00FF_00F0);
        wr(8'h08, 32'h0F00_F000);
        for (int i = 3; i < 10; i++) begin
            wr(addrs[i], $urandom());
            chk_pads("R9");
            rd_chk("R9", addrs[i]);
        end
        rd_chk("R9", 8'h00);
        rd_chk("R9", 8'h08);

        // R10: strobe low, address and data wiggle
        @(negedge clk);
        bus_addr  = 8'h00;
        bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        bus_addr  = 8'h08;
        bus_wdata = 32'h0;
        @(negedge clk);
        chk_pads("R10");
        rd_chk("R10", 8'h00);
        rd_chk("R10", 8'h08);

        // Random mix
        for (int it = 0; it < 200; it++) begin
            int k;
            k = $urandom_range(0, 9);
            wr(addrs[k], $urandom());
            if ($urandom_range(0, 2) == 0) set_pins($urandom());
            chk_pads("R4");
            k = $urandom_range(0, 6);
            rd_chk("R5", addrs[k]);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule